// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits beside a small microcontroller core and decides which clock domains run while the core sleeps. Software arms it with a sleep-enable bit and a two-bit mode field. It then pulses a sleep strobe. If the block is armed and the mode is legal, it enters sleep. It drops the clock enables for the selected mode and holds the core halted. Clock enables exist for CPU, flash, I/O, ADC and oscillator.

While asleep, the block watches the interrupt request lines and their enables. It applies a per-mode filter, so that only sources able to run in that mode can wake the device. External line 0 gets extra treatment. Its edge requests count only in Idle. Its level requests must be held for a minimum number of cycles. After a Power-down wake, the block runs only the oscillator domain for a programmable start-up count. In every mode it then holds the core halted for four more cycles with all clocks running, and after that the core resumes at the instruction following sleep. No reset or clear is issued. A reset during sleep returns the block to the running state, and the reset is recorded as the wake cause.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A sleep strobe while `sleep_en` is 0 has no effect. A strobe with mode value 3 (reserved) also has no effect: `clk_en` stays 5'b11111 and `core_halt` stays 0.
- R2: `clk_en` bit positions are 0 CPU, 1 flash, 2 I/O, 3 ADC, 4 oscillator. While asleep the value depends on the mode:
  - Mode 0 (Idle) gives 5'b11100.
  - Mode 1 (ADC noise reduction) gives 5'b11000.
  - Mode 2 (Power-down) gives 5'b00000.
  - While running and during the post-wake halt, the value is 5'b11111.
- R3: `core_halt` is 1 from the edge that accepts the strobe until the core resumes, and 0 otherwise (including after reset).
- R4: Line i (i ≥ 1) wakes the device only in certain modes, given by the parameter masks. The default masks allow lines 1 to 2 in mode 1 and line 1 only in mode 2. Idle accepts every line.
- R5: Line 0 has two request types:
  - An edge request (`ext_level`=0) wakes only in Idle, on the first edge where it is seen.
  - A level request (`ext_level`=1) wakes in any mode, but only after it has been high for HOLD_CYC consecutive edges. A shorter pulse is ignored.
- R6: A Power-down wake with nonzero `startup_cycles` spends that many edges with `osc_ready`=1 in start-up, with `clk_en`=5'b10000. Edges where `osc_ready` is low do not count. Other modes, and a count of 0, skip start-up.
- R7: After a wake (and after start-up, if any), `core_halt` stays 1 for exactly 4 edges with all clocks enabled before it returns to 0.
- R8: A reset while asleep or in start-up returns the block to running and sets `wake_valid`=1 and `wake_by_reset`=1. A reset while running clears `wake_valid`.
- R9: On an interrupt wake, `wake_valid`=1, `wake_by_reset`=0 and `wake_irq_idx` gives the lowest-index qualifying line. Entering sleep clears `wake_valid`.
- R10: A request on a line whose `irq_en` bit is 0 never wakes the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep arming bit |
| sleep_mode | input | 2 | Mode select: 0 Idle, 1 ADC noise reduction, 2 Power-down, 3 reserved |
| sleep_strobe | input | 1 | Sleep instruction pulse |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| ext_level | input | 1 | Line 0 is level-triggered when 1 |
| osc_ready | input | 1 | Oscillator stable indication |
| startup_cycles | input | SU_W | Start-up count after Power-down |
| clk_en | output | 5 | Domain clock enables |
| core_halt | output | 1 | Holds the core stopped |
| wake_valid | output | 1 | Wake cause recorded |
| wake_by_reset | output | 1 | Last sleep ended by reset |
| wake_irq_idx | output | IDX_W | Line that ended the last sleep |

## Verification
The bench sweeps every legal mode against every request line, both line-0 trigger types and both enable states. Each combination is compared to an arithmetic prediction of whether a wake happens and how many edges pass before `core_halt` falls. This separates the mode masks, the edge/level rule for line 0 and the fixed halt length. Directed patterns cover the following:
- Short level pulses, which must be rejected.
- Stalls of `osc_ready` and a zero start-up count, which show that the start-up count depends only on oscillator-ready edges.
- Simultaneous requests, which expose the priority.
- Resets in both states, which distinguish the reset-cause path from the interrupt path.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCNR = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_RSVD  = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_START,
        ST_HALT
    } slp_state_e;

    // bit 0 cpu ... bit 4 oscillator
    typedef struct packed {
        logic osc;
        logic adc;
        logic io;
        logic flash;
        logic cpu;
    } dom_en_t;

    localparam int POST_WAKE_HALT = 4;

    function automatic dom_en_t gate_for(slp_state_e st, slp_mode_e m);
        dom_en_t g;
        g = '{osc: 1'b1, adc: 1'b1, io: 1'b1, flash: 1'b1, cpu: 1'b1};
        if (st == ST_START) begin
            g = '{osc: 1'b1, adc: 1'b0, io: 1'b0, flash: 1'b0, cpu: 1'b0};
        end else if (st == ST_SLEEP) begin
            case (m)
                MODE_IDLE:  g = '{osc: 1'b1, adc: 1'b1, io: 1'b1, flash: 1'b0, cpu: 1'b0};
                MODE_ADCNR: g = '{osc: 1'b1, adc: 1'b1, io: 1'b0, flash: 1'b0, cpu: 1'b0};
                MODE_PDOWN: g = '0;
                default:    g = '{osc: 1'b1, adc: 1'b1, io: 1'b1, flash: 1'b1, cpu: 1'b1};
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
    import slp_pkg::*;
#(
    parameter int                 N_IRQ      = 4,
    parameter int                 HOLD_CYC   = 3,
    parameter logic [N_IRQ-1:0]   ADCNR_MASK = 4'b0111,
    parameter logic [N_IRQ-1:0]   PD_MASK    = 4'b0011,
    localparam int                IDX_W      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int                HW         = $clog2(HOLD_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  slp_mode_e        mode,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ext_level,
    output logic             wake,
    output logic [IDX_W-1:0] wake_idx
);

    logic [HW-1:0]    hold_cnt;
    logic             line0_on;
    logic             level_ok;
    logic [N_IRQ-1:0] mode_mask;
    logic [N_IRQ-1:0] cand;
    logic [N_IRQ-1:0] grant;

    assign line0_on = irq_req[0] & irq_en[0];

    always_ff @(posedge clk) begin
        if (rst || !active || !line0_on) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HW'(HOLD_CYC - 1)) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    assign level_ok = line0_on && (hold_cnt == HW'(HOLD_CYC - 1));

    always_comb begin
        case (mode)
            MODE_IDLE:  mode_mask = '1;
            MODE_ADCNR: mode_mask = ADCNR_MASK;
            MODE_PDOWN: mode_mask = PD_MASK;
            default:    mode_mask = '0;
        endcase
    end

    always_comb begin
        cand = irq_req & irq_en & mode_mask;
        cand[0] = ext_level ? level_ok : (line0_on && mode == MODE_IDLE);
        if (!active) cand = '0;
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        grant    = '0;
        wake_idx = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (cand[i] && !found) begin
                grant[i] = 1'b1;
                wake_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    assign wake = |grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R9

    AST_DEEP_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (active && mode != MODE_IDLE && !ext_level) |-> !grant[0]); // R5

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (grant & ~irq_en) == '0); // R10

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import slp_pkg::*;
#(
    parameter int  SU_W  = 4,
    parameter int  IDX_W = 2,
    localparam int HCW   = $clog2(POST_WAKE_HALT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_en,
    input  logic [1:0]       sleep_mode,
    input  logic             sleep_strobe,
    input  logic             wake,
    input  logic [IDX_W-1:0] wake_idx,
    input  logic             osc_ready,
    input  logic [SU_W-1:0]  startup_cycles,
    output slp_mode_e        mode_q,
    output logic             sleeping,
    output dom_en_t          dom_en,
    output logic             core_halt,
    output logic             wake_valid,
    output logic             wake_by_reset,
    output logic [IDX_W-1:0] wake_irq_idx
);

    slp_state_e      state;
    logic [SU_W-1:0] su_cnt;
    logic [HCW-1:0]  hcnt;
    logic            enter;

    assign enter = sleep_strobe && sleep_en && (slp_mode_e'(sleep_mode) != MODE_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_valid    <= (state == ST_SLEEP) || (state == ST_START);
            wake_by_reset <= (state == ST_SLEEP) || (state == ST_START);
            wake_irq_idx  <= '0;
            state         <= ST_RUN;
            mode_q        <= MODE_IDLE;
            su_cnt        <= '0;
            hcnt          <= '0;
        end else begin
            case (state)
                ST_RUN: if (enter) begin
                    state         <= ST_SLEEP;
                    mode_q        <= slp_mode_e'(sleep_mode);
                    wake_valid    <= 1'b0;
                    wake_by_reset <= 1'b0;
                    wake_irq_idx  <= '0;
                end
                ST_SLEEP: if (wake) begin
                    wake_valid    <= 1'b1;
                    wake_by_reset <= 1'b0;
                    wake_irq_idx  <= wake_idx;
                    su_cnt        <= '0;
                    hcnt          <= '0;
                    state <= (mode_q == MODE_PDOWN && startup_cycles != '0) ? ST_START : ST_HALT;
                end
                ST_START: if (osc_ready) begin
                    if (su_cnt == startup_cycles - 1'b1) state <= ST_HALT;
                    else su_cnt <= su_cnt + 1'b1;
                end
                default: begin
                    if (hcnt == HCW'(POST_WAKE_HALT - 1)) state <= ST_RUN;
                    else hcnt <= hcnt + 1'b1;
                end
            endcase
        end
    end

    assign sleeping  = (state == ST_SLEEP);
    assign dom_en    = gate_for(state, mode_q);
    assign core_halt = (state != ST_RUN);

    AST_NO_STRAY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !enter) |=> state == ST_RUN); // R1

    AST_HALT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && hcnt == HCW'(POST_WAKE_HALT - 1)) |=> state == ST_RUN); // R7

    AST_SHALLOW_NO_STARTUP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && wake && mode_q != MODE_PDOWN) |=> state == ST_HALT); // R6

    AST_START_STALL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && !osc_ready) |=> (state == ST_START && $stable(su_cnt))); // R6

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slp_pkg::*;
#(
    parameter int               N_IRQ      = 4,
    parameter int               HOLD_CYC   = 3,
    parameter int               SU_W       = 4,
    parameter logic [N_IRQ-1:0] ADCNR_MASK = 4'b0111,
    parameter logic [N_IRQ-1:0] PD_MASK    = 4'b0011,
    localparam int              IDX_W      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_en,
    input  logic [1:0]       sleep_mode,
    input  logic             sleep_strobe,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ext_level,
    input  logic             osc_ready,
    input  logic [SU_W-1:0]  startup_cycles,
    output logic [4:0]       clk_en,
    output logic             core_halt,
    output logic             wake_valid,
    output logic             wake_by_reset,
    output logic [IDX_W-1:0] wake_irq_idx
);

    slp_mode_e        mode_q;
    logic             sleeping;
    logic             wake;
    logic [IDX_W-1:0] wake_idx;
    dom_en_t          dom_en;

    sleep_wake_filter #(
        .N_IRQ      (N_IRQ),
        .HOLD_CYC   (HOLD_CYC),
        .ADCNR_MASK (ADCNR_MASK),
        .PD_MASK    (PD_MASK)
    ) i_filter (
        .clk       (clk),
        .rst       (rst),
        .active    (sleeping),
        .mode      (mode_q),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .ext_level (ext_level),
        .wake      (wake),
        .wake_idx  (wake_idx)
    );

    sleep_seq #(
        .SU_W  (SU_W),
        .IDX_W (IDX_W)
    ) i_seq (
        .clk            (clk),
        .rst            (rst),
        .sleep_en       (sleep_en),
        .sleep_mode     (sleep_mode),
        .sleep_strobe   (sleep_strobe),
        .wake           (wake),
        .wake_idx       (wake_idx),
        .osc_ready      (osc_ready),
        .startup_cycles (startup_cycles),
        .mode_q         (mode_q),
        .sleeping       (sleeping),
        .dom_en         (dom_en),
        .core_halt      (core_halt),
        .wake_valid     (wake_valid),
        .wake_by_reset  (wake_by_reset),
        .wake_irq_idx   (wake_irq_idx)
    );

    assign clk_en = dom_en;

    AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (sleeping && mode_q == MODE_PDOWN) |-> clk_en == 5'b00000); // R2

    AST_HALT_WHILE_GATED: assert property (@(posedge clk) disable iff (rst)
        (clk_en != 5'b11111) |-> core_halt); // R3

endmodule

// File: tb/test_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module test_sleep_clk_ctrl;

    localparam int N_IRQ = 4;
    localparam int HOLD  = 3;
    localparam int SU_W  = 4;
    localparam int D     = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sleep_en = 1'b0;
    logic [1:0]       sleep_mode = 2'b00;
    logic             sleep_strobe = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             ext_level = 1'b0;
    logic             osc_ready = 1'b1;
    logic [SU_W-1:0]  startup_cycles = SU_W'(D);
    logic [4:0]       clk_en;
    logic             core_halt;
    logic             wake_valid;
    logic             wake_by_reset;
    logic [1:0]       wake_irq_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sleep_clk_ctrl #(
        .N_IRQ    (N_IRQ),
        .HOLD_CYC (HOLD),
        .SU_W     (SU_W)
    ) i_sleep_clk_ctrl (
        .clk            (clk),
        .rst            (rst),
        .sleep_en       (sleep_en),
        .sleep_mode     (sleep_mode),
        .sleep_strobe   (sleep_strobe),
        .irq_req        (irq_req),
        .irq_en         (irq_en),
        .ext_level      (ext_level),
        .osc_ready      (osc_ready),
        .startup_cycles (startup_cycles),
        .clk_en         (clk_en),
        .core_halt      (core_halt),
        .wake_valid     (wake_valid),
        .wake_by_reset  (wake_by_reset),
        .wake_irq_idx   (wake_irq_idx)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gate_of(input int m);
        if (m == 0) return 5'b11100;
        if (m == 1) return 5'b11000;
        return 0;
    endfunction

    function automatic bit wakes(input int m, input int ln, input int lvl, input int en);
        if (en == 0) return 0;
        if (ln == 0) return (lvl != 0) || (m == 0);
        return (m == 0) || (m == 1 && ln <= 2) || (m == 2 && ln <= 1);
    endfunction

    task automatic enter(input int m);
        sleep_en = 1'b1; sleep_mode = 2'(m); sleep_strobe = 1'b1;
        step();
        sleep_strobe = 1'b0;
        chk("R2 sleep gating", clk_en, gate_of(m));
        chk("R3 halt on entry", core_halt, 1);
        chk("R9 cause cleared on entry", wake_valid, 0);
    endtask

    // returns edges from request until core_halt falls
    task automatic run_to_resume(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (core_halt && n < 200);
    endtask

    task automatic exit_by_line1();
        int n;
        irq_en = 4'b0010; irq_req = 4'b0010;
        run_to_resume(n);
        irq_req = '0; irq_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        step(); step();
        rst = 1'b0;
        step();
        chk("R2 reset clk_en", clk_en, 5'b11111);
        chk("R3 reset halt", core_halt, 0);
        chk("R8 reset cause", wake_valid, 0);

        // R1: disarmed strobe and reserved mode
        sleep_en = 1'b0; sleep_mode = 2'b00; sleep_strobe = 1'b1;
        step(); sleep_strobe = 1'b0; step();
        chk("R1 disarmed clk_en", clk_en, 5'b11111);
        chk("R1 disarmed halt", core_halt, 0);
        sleep_en = 1'b1; sleep_mode = 2'b11; sleep_strobe = 1'b1;
        step(); sleep_strobe = 1'b0; step();
        chk("R1 reserved clk_en", clk_en, 5'b11111);
        chk("R1 reserved halt", core_halt, 0);

        // sweep: R4 R5 R6 R7 R9 R10
        for (int m = 0; m < 3; m++) begin
            for (int ln = 0; ln < N_IRQ; ln++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    for (int en = 0; en < 2; en++) begin
                        enter(m);
                        ext_level = lvl[0];
                        irq_en  = (en != 0) ? 4'(1 << ln) : 4'b0000;
                        irq_req = 4'(1 << ln);
                        if (wakes(m, ln, lvl, en)) begin
                            int exp_n;
                            exp_n = ((ln == 0 && lvl != 0) ? HOLD : 1) + 4 + ((m == 2) ? D : 0);
                            run_to_resume(n);
                            chk("R4 R5 R6 R7 resume latency", n, exp_n);
                            chk("R9 wake valid", wake_valid, 1);
                            chk("R9 not reset", wake_by_reset, 0);
                            chk("R9 wake index", wake_irq_idx, ln);
                            chk("R2 run clk_en", clk_en, 5'b11111);
                            irq_req = '0;
                        end else begin
                            repeat (12) step();
                            chk("R4 R5 R10 still asleep", core_halt, 1);
                            chk("R4 R5 R10 gating kept", clk_en, gate_of(m));
                            chk("R4 R5 R10 no cause", wake_valid, 0);
                            irq_req = '0;
                            ext_level = 1'b0;
                            exit_by_line1();
                        end
                        ext_level = 1'b0;
                        step();
                    end
                end
            end
        end

        // R5: short level pulse ignored in Power-down
        enter(2);
        ext_level = 1'b1; irq_en = 4'b0001; irq_req = 4'b0001;
        repeat (HOLD - 1) step();
        irq_req = '0;
        repeat (4) step();
        chk("R5 short pulse ignored", core_halt, 1);
        chk("R5 short pulse gating", clk_en, 0);
        irq_req = 4'b0001;
        run_to_resume(n);
        chk("R5 full hold wakes", n, HOLD + D + 4);
        irq_req = '0; irq_en = '0; ext_level = 1'b0;

        // R6: oscillator stall extends start-up
        enter(2);
        osc_ready = 1'b0;
        irq_en = 4'b0010; irq_req = 4'b0010;
        step();
        chk("R6 start-up osc only", clk_en, 5'b10000);
        repeat (6) step();
        chk("R6 stalled still osc only", clk_en, 5'b10000);
        osc_ready = 1'b1;
        run_to_resume(n);
        chk("R6 R7 after stall", n, D + 4);
        irq_req = '0; irq_en = '0;

        // R6: zero start-up count
        startup_cycles = '0;
        enter(2);
        irq_en = 4'b0010; irq_req = 4'b0010;
        step();
        chk("R7 halt clocks on", clk_en, 5'b11111);
        chk("R7 halt held", core_halt, 1);
        run_to_resume(n);
        chk("R6 zero count", n, 4);
        irq_req = '0; irq_en = '0;
        startup_cycles = SU_W'(D);

        // R9: priority
        enter(0);
        irq_en = 4'b1010; irq_req = 4'b1010;
        run_to_resume(n);
        chk("R9 priority 1 over 3", wake_irq_idx, 1);
        irq_req = '0;
        enter(0);
        irq_en = 4'b1100; irq_req = 4'b1100;
        run_to_resume(n);
        chk("R9 priority 2 over 3", wake_irq_idx, 2);
        irq_req = '0; irq_en = '0;

        // R8: reset in sleep and in start-up, then in run
        enter(2);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R8 reset wake clk_en", clk_en, 5'b11111);
        chk("R8 reset wake halt", core_halt, 0);
        chk("R8 reset cause valid", wake_valid, 1);
        chk("R8 reset cause flag", wake_by_reset, 1);
        enter(2);
        irq_en = 4'b0010; irq_req = 4'b0010;
        step();
        rst = 1'b1; step(); rst = 1'b0;
        irq_req = '0; irq_en = '0;
        chk("R8 reset in start-up", wake_by_reset, 1);
        chk("R8 reset in start-up halt", core_halt, 0);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R8 reset in run clears", wake_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule